// File: doc/BRIEF.md
# Timer/Counter with Shared Assignable Prescaler

This block is an 8-bit timer/counter for a small microcontroller core. It has a single binary prescaler, and that prescaler works for exactly one client at a time. One client is the timer. The other is a watchdog tick path that feeds an external timeout counter.

The timer counts one of two sources:
- the core's instruction-cycle tick, or
- edges on an external count pin, after the pin passes through a synchronizer.

A six-bit control word selects the source and the active edge. It also chooses which client owns the prescaler and sets the divide ratio. The two clients use different ratio mappings for the same select value.

Software can load the timer through a write strobe. Every such load also zeroes the prescaler. A watchdog-clear strobe zeroes the prescaler only while the watchdog path owns it. The overflow flag latches when the timer wraps and stays set until it is cleared.

Top module: `tmr_presc_top`

## Requirements
- R1: After reset `tmr_value` is 0, `ovf_flag` is 0, `wdt_tick` is 0 and the prescaler count is 0.
- R2: With `cfg_word[5]`=0 (internal source), the timer source tick is `icyc_tick`, sampled at each clock edge. The timer changes at most by +1 per clock, except on a load.
- R3: Counter mode is selected by `cfg_word[5]`=1. `cfg_word[4]`=0 selects rising edges of `ext_pin` and 1 selects falling edges. Each qualifying edge gives exactly one source tick, and `icyc_tick` is ignored. A pin change made before clock edge k increments the timer at clock edge k+2, which is visible after edge k+2.
- R4: With `cfg_word[3]`=0 the prescaler belongs to the timer. The timer then advances once per 2^(`cfg_word[2:0]`+1) source ticks: 1:2 for select 0 and 1:256 for select 7.
- R5: With `cfg_word[3]`=1 the timer advances on every source tick (1:1). The watchdog tick path then produces one `wdt_tick` per 2^(`cfg_word[2:0]`) `wdt_base_tick` pulses: select 5 gives 1:32 and select 0 gives 1:1.
- R6: With `cfg_word[3]`=0, `wdt_tick` repeats `wdt_base_tick` undivided, delayed by one clock.
- R7: When `tmr_wr_en` is high, the next value of `tmr_value` is `tmr_wr_data`. No increment applies in that cycle, and the prescaler count returns to 0.
- R8: `wdt_clr` zeroes the prescaler only while `cfg_word[3]`=1. While the timer owns the prescaler, `wdt_clr` does not affect the timer's division.
- R9: `ovf_flag` sets when an increment takes the timer from 8'hFF to 8'h00. It stays set until `ovf_clr` is pulsed. A wrap in the same cycle as `ovf_clr` leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| icyc_tick | input | 1 | Instruction-cycle tick, one clock wide |
| ext_pin | input | 1 | External count pin, asynchronous |
| cfg_word | input | 6 | [5] source, [4] falling edge, [3] prescaler to watchdog, [2:0] ratio select |
| tmr_wr_en | input | 1 | Timer register write strobe |
| tmr_wr_data | input | 8 | Timer register write value |
| wdt_clr | input | 1 | Watchdog-clear strobe |
| wdt_base_tick | input | 1 | Undivided watchdog base tick |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| tmr_value | output | 8 | Current timer value |
| ovf_flag | output | 1 | Sticky overflow flag |
| wdt_tick | output | 1 | Tick to the watchdog timeout counter |

## Verification
The assertions check these properties on every cycle:
- timer loads;
- the +0/+1 step limit;
- 1:1 counting while the watchdog owns the prescaler;
- undivided watchdog ticks while the timer owns it;
- prescaler clearing by a load or by a watchdog clear;
- the wrap-only, sticky behaviour of the overflow flag.

Only the bench scenarios can show the following:
- the exact divide ratios of both mappings;
- the two-stage synchronizer latency and the edge polarity;
- that a watchdog clear leaves the timer's division untouched;
- that a load discards a partly filled prescaler.

// File: rtl/tmr_presc_pkg.sv
package tmr_presc_pkg;

  localparam int PS_W  = 3;
  localparam int CFG_W = PS_W + 3;

  typedef struct packed {
    logic            src_ext;
    logic            edge_fall;
    logic            to_wdt;
    logic [PS_W-1:0] ratio_sel;
  } tmr_cfg_t;

  // Divide ratio of the shared prescaler for a given owner and select.
  function automatic int unsigned presc_ratio(input logic to_wdt,
                                              input int unsigned sel);
    int unsigned sh;
    sh = to_wdt ? sel : sel + 1;
    return 32'd1 << sh;
  endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic sel_fall,
  output logic edge_pulse
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= pin;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= 1'b0;
      else        sync_q[s] <= sync_q[s-1];
    end
  end

  assign synced = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= synced;
  end

  assign edge_pulse = sel_fall ? (prev_q & ~synced) : (~prev_q & synced);

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_in,
  input  logic                   clr,
  input  logic                   to_wdt,
  input  logic [SEL_W-1:0]       sel,
  output logic                   tick_out,
  output logic [(1<<SEL_W)-1:0]  cnt_out
);
  import tmr_presc_pkg::*;

  localparam int CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic             at_last;

  always_comb begin
    last_cnt = CNT_W'(presc_ratio(to_wdt, int'(sel)) - 32'd1);
  end

  // Greater-or-equal so a ratio lowered mid-count still terminates.
  assign at_last  = (cnt_q >= last_cnt);
  assign tick_out = tick_in & at_last & ~clr;
  assign cnt_out  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (tick_in) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end

endmodule

// File: rtl/tmr_count8.sv
module tmr_count8 #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [TMR_W-1:0] wr_data,
  input  logic             inc,
  input  logic             ovf_clr,
  output logic [TMR_W-1:0] value,
  output logic             ovf,
  output logic             wrap_evt
);

  logic [TMR_W-1:0] val_q;
  logic             ovf_q;
  logic             step;

  assign step     = inc & ~wr_en;
  assign wrap_evt = step & (val_q == {TMR_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     val_q <= '0;
    else if (wr_en) val_q <= wr_data;
    else if (step)  val_q <= val_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_q <= 1'b0;
    else if (wrap_evt) ovf_q <= 1'b1;
    else if (ovf_clr)  ovf_q <= 1'b0;
  end

  assign value = val_q;
  assign ovf   = ovf_q;

endmodule

// File: rtl/tmr_presc_top.sv
module tmr_presc_top #(
  parameter int TMR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            icyc_tick,
  input  logic                            ext_pin,
  input  logic [tmr_presc_pkg::CFG_W-1:0] cfg_word,
  input  logic                            tmr_wr_en,
  input  logic [TMR_W-1:0]                tmr_wr_data,
  input  logic                            wdt_clr,
  input  logic                            wdt_base_tick,
  input  logic                            ovf_clr,
  output logic [TMR_W-1:0]                tmr_value,
  output logic                            ovf_flag,
  output logic                            wdt_tick
);
  import tmr_presc_pkg::*;

  localparam int PRESC_W = 1 << PS_W;

  tmr_cfg_t           cfg;
  logic               cfg_src_ext;
  logic               cfg_to_wdt;
  logic               ext_edge_w;
  logic               src_tick_w;
  logic               presc_in_w;
  logic               presc_out_w;
  logic               presc_clr_w;
  logic [PRESC_W-1:0] presc_cnt_w;
  logic               tmr_inc_w;
  logic               wdt_evt_w;
  logic               wrap_evt_w;
  logic               wdt_tick_q;

  assign cfg         = tmr_cfg_t'(cfg_word);
  assign cfg_src_ext = cfg.src_ext;
  assign cfg_to_wdt  = cfg.to_wdt;

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin        (ext_pin),
    .sel_fall   (cfg.edge_fall),
    .edge_pulse (ext_edge_w)
  );

  assign src_tick_w  = cfg.src_ext ? ext_edge_w : icyc_tick;
  assign presc_in_w  = cfg.to_wdt ? wdt_base_tick : src_tick_w;
  assign presc_clr_w = tmr_wr_en | (wdt_clr & cfg.to_wdt);

  tmr_prescaler #(.SEL_W(PS_W)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_in  (presc_in_w),
    .clr      (presc_clr_w),
    .to_wdt   (cfg.to_wdt),
    .sel      (cfg.ratio_sel),
    .tick_out (presc_out_w),
    .cnt_out  (presc_cnt_w)
  );

  assign tmr_inc_w = cfg.to_wdt ? src_tick_w    : presc_out_w;
  assign wdt_evt_w = cfg.to_wdt ? presc_out_w   : wdt_base_tick;

  tmr_count8 #(.TMR_W(TMR_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tmr_wr_en),
    .wr_data  (tmr_wr_data),
    .inc      (tmr_inc_w),
    .ovf_clr  (ovf_clr),
    .value    (tmr_value),
    .ovf      (ovf_flag),
    .wrap_evt (wrap_evt_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdt_tick_q <= 1'b0;
    else        wdt_tick_q <= wdt_evt_w;
  end

  assign wdt_tick = wdt_tick_q;

endmodule

// File: rtl/tmr_presc_chk.sv
module tmr_presc_chk #(
  parameter int TMR_W = 8,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             icyc_tick,
  input logic             cfg_src_ext,
  input logic             cfg_to_wdt,
  input logic             tmr_wr_en,
  input logic [TMR_W-1:0] tmr_wr_data,
  input logic             wdt_clr,
  input logic             wdt_base_tick,
  input logic             ovf_clr,
  input logic [TMR_W-1:0] tmr_value,
  input logic             ovf_flag,
  input logic             wdt_tick,
  input logic [CNT_W-1:0] presc_cnt
);

  a_r7_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wr_en |=> tmr_value == $past(tmr_wr_data));

  a_r7_write_clears_presc: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wr_en |=> presc_cnt == '0);

  a_r8_wdt_clr_presc: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_clr && cfg_to_wdt) |=> presc_cnt == '0);

  a_r2_step_limit: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_wr_en |=> (tmr_value == $past(tmr_value)) ||
                   (tmr_value == $past(tmr_value) + 1'b1));

  a_r5_timer_one_to_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_to_wdt && !cfg_src_ext && !tmr_wr_en) |=>
      tmr_value == $past(tmr_value) + TMR_W'($past(icyc_tick)));

  a_r6_wdt_direct: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_to_wdt |=> wdt_tick == $past(wdt_base_tick));

  a_r9_ovf_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(tmr_value) == {TMR_W{1'b1}}) && (tmr_value == '0));

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

endmodule

bind tmr_presc_top tmr_presc_chk #(.TMR_W(TMR_W), .CNT_W(PRESC_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .icyc_tick     (icyc_tick),
  .cfg_src_ext   (cfg_src_ext),
  .cfg_to_wdt    (cfg_to_wdt),
  .tmr_wr_en     (tmr_wr_en),
  .tmr_wr_data   (tmr_wr_data),
  .wdt_clr       (wdt_clr),
  .wdt_base_tick (wdt_base_tick),
  .ovf_clr       (ovf_clr),
  .tmr_value     (tmr_value),
  .ovf_flag      (ovf_flag),
  .wdt_tick      (wdt_tick),
  .presc_cnt     (presc_cnt_w)
);

// File: tb/tmr_presc_top_tb_top.sv
`timescale 1ns/1ps
module tmr_presc_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       icyc_tick = 1'b0;
  logic       ext_pin = 1'b0;
  logic [5:0] cfg_word = 6'd0;
  logic       tmr_wr_en = 1'b0;
  logic [7:0] tmr_wr_data = 8'd0;
  logic       wdt_clr = 1'b0;
  logic       wdt_base_tick = 1'b0;
  logic       ovf_clr = 1'b0;
  logic [7:0] tmr_value;
  logic       ovf_flag;
  logic       wdt_tick;

  int checks = 0;
  int errors = 0;
  int wdt_seen = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_presc_top dut_i (
    .clk(clk), .rst_n(rst_n), .icyc_tick(icyc_tick), .ext_pin(ext_pin),
    .cfg_word(cfg_word), .tmr_wr_en(tmr_wr_en), .tmr_wr_data(tmr_wr_data),
    .wdt_clr(wdt_clr), .wdt_base_tick(wdt_base_tick), .ovf_clr(ovf_clr),
    .tmr_value(tmr_value), .ovf_flag(ovf_flag), .wdt_tick(wdt_tick)
  );

  always @(negedge clk) if (rst_n && wdt_tick) wdt_seen++;

  // Expected timer advance for n source ticks from a cleared prescaler.
  function automatic int exp_steps(int n, bit to_wdt, int sel);
    int div;
    div = to_wdt ? 1 : (2 << sel);
    return n / div;
  endfunction

  function automatic int exp_wdt_ticks(int n, int sel);
    return n / (1 << sel);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(bit src, bit fall, bit to_wdt, int sel);
    @(negedge clk);
    cfg_word = {src, fall, to_wdt, 3'(sel)};
  endtask

  task automatic icyc_pulses(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) icyc_tick = 1'b1;
      @(negedge clk) icyc_tick = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic base_pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) wdt_base_tick = 1'b1;
      @(negedge clk) wdt_base_tick = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic write_tmr(int v);
    @(negedge clk); tmr_wr_en = 1'b1; tmr_wr_data = 8'(v);
    @(negedge clk); tmr_wr_en = 1'b0;
  endtask

  task automatic strobe_wdt_clr();
    @(negedge clk) wdt_clr = 1'b1;
    @(negedge clk) wdt_clr = 1'b0;
  endtask

  task automatic strobe_ovf_clr();
    @(negedge clk) ovf_clr = 1'b1;
    @(negedge clk) ovf_clr = 1'b0;
  endtask

  task automatic pin_to(bit b);
    @(negedge clk) ext_pin = b;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int base, start, n, sel, total;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 timer reset", tmr_value, 0);
    chk("R1 ovf reset", ovf_flag, 0);
    chk("R1 wdt_tick reset", wdt_tick, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 timer after release", tmr_value, 0);

    // R4 timer ratios, internal source (R2)
    set_cfg(0, 0, 0, 0); write_tmr(0); icyc_pulses(10, 0);
    chk("R4 sel0 1:2", tmr_value, exp_steps(10, 0, 0));
    set_cfg(0, 0, 0, 2); write_tmr(0); icyc_pulses(40, 1);
    chk("R4 sel2 1:8", tmr_value, exp_steps(40, 0, 2));
    set_cfg(0, 0, 0, 7); write_tmr(0); icyc_pulses(256, 0);
    chk("R4 sel7 1:256", tmr_value, 1);
    icyc_pulses(255, 0);
    chk("R4 sel7 no early step", tmr_value, 1);
    icyc_pulses(1, 0);
    chk("R4 sel7 second step", tmr_value, 2);

    // R5 timer 1:1 and watchdog division
    set_cfg(0, 0, 1, 5); write_tmr(0); icyc_pulses(7, 0);
    chk("R2 R5 timer 1:1", tmr_value, 7);
    strobe_wdt_clr(); base = wdt_seen; base_pulses(64);
    chk("R5 wdt 1:32 of 64", wdt_seen - base, exp_wdt_ticks(64, 5));
    base_pulses(31);
    chk("R5 wdt 1:32 partial", wdt_seen - base, 2);
    base_pulses(1);
    chk("R5 wdt 1:32 third", wdt_seen - base, 3);
    set_cfg(0, 0, 1, 0); strobe_wdt_clr(); base = wdt_seen; base_pulses(6);
    chk("R5 wdt 1:1", wdt_seen - base, 6);

    // R6 watchdog undivided when timer owns prescaler
    set_cfg(0, 0, 0, 3); base = wdt_seen; base_pulses(5);
    chk("R6 wdt direct", wdt_seen - base, 5);

    // R8 watchdog clear
    set_cfg(0, 0, 1, 3); strobe_wdt_clr(); base = wdt_seen;
    base_pulses(5); strobe_wdt_clr(); base_pulses(7);
    chk("R8 clear restarts wdt division", wdt_seen - base, 0);
    base_pulses(1);
    chk("R8 wdt after clear", wdt_seen - base, 1);
    set_cfg(0, 0, 0, 1); write_tmr(0); icyc_pulses(3, 0);
    strobe_wdt_clr(); icyc_pulses(1, 0);
    chk("R8 wdt_clr ignored for timer", tmr_value, 1);

    // R7 write clears prescaler, suppresses increment
    write_tmr(0); icyc_pulses(3, 0); write_tmr(8'h10); icyc_pulses(3, 0);
    chk("R7 write clears prescaler", tmr_value, 8'h10);
    icyc_pulses(1, 0);
    chk("R7 step after write", tmr_value, 8'h11);
    set_cfg(0, 0, 1, 0);
    @(negedge clk); tmr_wr_en = 1'b1; tmr_wr_data = 8'h40; icyc_tick = 1'b1;
    @(negedge clk); tmr_wr_en = 1'b0; icyc_tick = 1'b0;
    chk("R7 write suppresses increment", tmr_value, 8'h40);

    // R3 counter mode
    set_cfg(1, 0, 1, 0); write_tmr(0); repeat (4) @(negedge clk);
    for (int i = 0; i < 5; i++) begin pin_to(1); pin_to(0); end
    chk("R3 rising edges", tmr_value, 5);
    icyc_pulses(4, 0);
    chk("R3 icyc ignored", tmr_value, 5);
    @(negedge clk) ext_pin = 1'b1;
    @(negedge clk) chk("R3 latency edge k", tmr_value, 5);
    @(negedge clk) chk("R3 latency edge k+1", tmr_value, 5);
    @(negedge clk) chk("R3 latency edge k+2", tmr_value, 6);
    repeat (3) @(negedge clk);
    set_cfg(1, 1, 1, 0); repeat (4) @(negedge clk);
    chk("R3 falling mode hold high", tmr_value, 6);
    pin_to(0);
    chk("R3 falling edge counts", tmr_value, 7);
    pin_to(1);
    chk("R3 rising ignored in falling mode", tmr_value, 7);
    pin_to(0);
    set_cfg(1, 0, 0, 0); write_tmr(0);
    for (int i = 0; i < 6; i++) begin pin_to(1); pin_to(0); end
    chk("R3 R4 ext edges 1:2", tmr_value, 3);

    // R9 overflow
    set_cfg(0, 0, 1, 0); strobe_ovf_clr(); write_tmr(8'hFE); icyc_pulses(1, 0);
    chk("R9 at FF value", tmr_value, 8'hFF);
    chk("R9 no ovf at FF", ovf_flag, 0);
    icyc_pulses(1, 0);
    chk("R9 wrap value", tmr_value, 0);
    chk("R9 ovf set", ovf_flag, 1);
    icyc_pulses(1, 0);
    chk("R9 ovf sticky", ovf_flag, 1);
    strobe_ovf_clr();
    chk("R9 ovf cleared", ovf_flag, 0);
    write_tmr(8'hFF);
    @(negedge clk); icyc_tick = 1'b1; ovf_clr = 1'b1;
    @(negedge clk); icyc_tick = 1'b0; ovf_clr = 1'b0;
    chk("R9 set wins over clear", ovf_flag, 1);

    // Random: timer ratios with random starts and gaps
    set_cfg(0, 0, 0, 0);
    for (int it = 0; it < 24; it++) begin
      sel = int'($urandom % 4);
      start = int'($urandom % 256);
      n = int'($urandom % 41);
      set_cfg(0, 0, 0, sel); strobe_ovf_clr(); write_tmr(start);
      for (int k = 0; k < n; k++) icyc_pulses(1, int'($urandom % 3));
      total = start + exp_steps(n, 0, sel);
      chk("R4 random value", tmr_value, total % 256);
      chk("R9 random ovf", ovf_flag, (total > 255) ? 1 : 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule